// File: doc/BRIEF.md
# Outstanding Transaction Limiter

This block guards the request channel of one port. It keeps a single running count of the work in flight from that port. Reads and writes share the count. A read leaves the count when its final data beat comes back, and a write leaves when its response arrives. Every accepted request adds a weight to the count. A two-part DVM message weighs two, and any other request weighs its number of 64-byte granules.

When a new request would push the count past a programmable ceiling, the block drops its ready signal and holds the request off. Software sets the ceiling through a small write/read port. Values outside the hardware range are pulled to the nearest bound, and that bound is what reads back. Lowering the ceiling never discards work already in flight. The count simply drains until new requests fit again.

Top module: `ot_limiter`

## Requirements
- R1: After reset the count is zero, the limit reads back as MAX_OT, and a request of any weight up to MAX_OT sees ready high.
- R2: The weight of a request is 2 when req_dvm_i is 1, whatever req_gran_i holds. Otherwise it is req_gran_i, and a granule field of 0 counts as weight 1.
- R3: req_ready_o is high exactly when the count plus the weight of the presented request is no greater than the limit. A stalled request leaves the count unchanged.
- R4: One count serves both directions. A read-last event subtracts rd_last_wt_i and a write-response event subtracts wr_resp_wt_i. An accept and both retirements in the same cycle combine into one net update at the next clock edge.
- R5: A limit write below RSV_SLOTS+2 stores RSV_SLOTS+2, and that value reads back.
- R6: A limit write above MAX_OT stores MAX_OT. A write inside the range stores the value exactly. cfg_rdata_o shows the stored limit from the cycle after the write, and it is unchanged when no write occurs.
- R7: When the limit is lowered below the current count, the count is kept and only falls through retirements. Ready stays low until the count plus the request weight fits the new limit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid_i | input | 1 | A request is presented |
| req_gran_i | input | GRAN_W | Granule count of the presented request |
| req_dvm_i | input | 1 | The request is a two-part DVM message |
| req_ready_o | output | 1 | The request may be accepted this cycle |
| rd_last_i | input | 1 | Final read data beat of a transaction |
| rd_last_wt_i | input | WT_W | Weight released by that read |
| wr_resp_i | input | 1 | Write response of a transaction |
| wr_resp_wt_i | input | WT_W | Weight released by that write |
| cfg_wr_i | input | 1 | Limit register write strobe |
| cfg_wdata_i | input | CFG_W | Limit value to write |
| cfg_rdata_o | output | CFG_W | Stored limit readback |

## Verification
The bench builds the block with MAX_OT of 32, RSV_SLOTS of 2 (a floor of 4), a 3-bit granule field and an 8-bit configuration word. With these values, a handful of 7-granule requests reach the ceiling. An 8-bit write can also land below the floor, inside the range, or far above the ceiling. Directed steps land the count exactly on the limit and set an accept against a retirement in the same cycle. They also drop the limit under a full count. A long random run then mixes DVM and split requests with retirements and occasional limit writes, checking ready and readback every cycle against a bench model.

// File: rtl/ot_limiter_pkg.sv
package ot_limiter_pkg;

  // Weight field must hold both the largest granule count and the DVM weight of 2.
  function automatic int unsigned wt_width(int unsigned gran_w);
    return (gran_w < 2) ? 2 : gran_w;
  endfunction

  localparam int unsigned DVM_WEIGHT = 2;

endpackage

// File: rtl/ot_rst_sync.sv
module ot_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic rst_sync_no
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sync_q <= '0;
    else         sync_q <= sync_d;
  end

  assign rst_sync_no = sync_q[STAGES-1];
endmodule

// File: rtl/ot_weight.sv
module ot_weight #(
  parameter int unsigned GRAN_W = 3,
  parameter int unsigned WT_W   = 3
) (
  input  logic [GRAN_W-1:0] gran_i,
  input  logic              dvm_i,
  output logic [WT_W-1:0]   wt_o
);
  import ot_limiter_pkg::*;

  always_comb begin
    if (dvm_i)              wt_o = WT_W'(DVM_WEIGHT);
    else if (gran_i == '0)  wt_o = WT_W'(1);
    else                    wt_o = WT_W'(gran_i);
  end
endmodule

// File: rtl/ot_limit_reg.sv
module ot_limit_reg #(
  parameter int unsigned CFG_W  = 8,
  parameter int unsigned CNT_W  = 6,
  parameter int unsigned MIN_OT = 4,
  parameter int unsigned MAX_OT = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             wr_i,
  input  logic [CFG_W-1:0] wdata_i,
  output logic [CNT_W-1:0] limit_o
);
  logic [CNT_W-1:0] lim_q;
  logic [CNT_W-1:0] lim_d;

  // Clamp the written value into [MIN_OT, MAX_OT].
  always_comb begin
    lim_d = lim_q;
    if (wdata_i < CFG_W'(MIN_OT))      lim_d = CNT_W'(MIN_OT);
    else if (wdata_i > CFG_W'(MAX_OT)) lim_d = CNT_W'(MAX_OT);
    else                               lim_d = wdata_i[CNT_W-1:0];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   lim_q <= CNT_W'(MAX_OT);
    else if (wr_i) lim_q <= lim_d;
  end

  assign limit_o = lim_q;
endmodule

// File: rtl/ot_counter.sv
module ot_counter #(
  parameter int unsigned CNT_W = 6,
  parameter int unsigned WT_W  = 3
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [CNT_W-1:0] limit_i,
  input  logic             req_valid_i,
  input  logic [WT_W-1:0]  req_wt_i,
  output logic             req_ready_o,
  input  logic             rd_ret_i,
  input  logic [WT_W-1:0]  rd_ret_wt_i,
  input  logic             wr_ret_i,
  input  logic [WT_W-1:0]  wr_ret_wt_i,
  output logic [CNT_W-1:0] occ_o
);
  localparam int unsigned SUM_W = CNT_W + 2;

  logic [CNT_W-1:0] occ_q;
  logic [CNT_W-1:0] occ_d;
  logic [SUM_W-1:0] sum_req;
  logic [SUM_W-1:0] grow;
  logic [SUM_W-1:0] shrink;
  logic             accept;
  logic             upd_en;

  always_comb begin
    sum_req     = SUM_W'(occ_q) + SUM_W'(req_wt_i);
    req_ready_o = (sum_req <= SUM_W'(limit_i));
    accept      = req_valid_i && req_ready_o;
    grow        = SUM_W'(occ_q) + (accept ? SUM_W'(req_wt_i) : '0);
    shrink      = (rd_ret_i ? SUM_W'(rd_ret_wt_i) : '0)
                + (wr_ret_i ? SUM_W'(wr_ret_wt_i) : '0);
    // One net update per cycle; guard against a stray over-retirement.
    occ_d       = (grow >= shrink) ? CNT_W'(grow - shrink) : '0;
    upd_en      = accept || rd_ret_i || wr_ret_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     occ_q <= '0;
    else if (upd_en) occ_q <= occ_d;
  end

  assign occ_o = occ_q;
endmodule

// File: rtl/ot_limiter.sv
module ot_limiter #(
  parameter int unsigned MAX_OT    = 32,
  parameter int unsigned RSV_SLOTS = 2,
  parameter int unsigned GRAN_W    = 3,
  parameter int unsigned CFG_W     = 8,
  localparam int unsigned WT_W     = ot_limiter_pkg::wt_width(GRAN_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [GRAN_W-1:0] req_gran_i,
  input  logic              req_dvm_i,
  output logic              req_ready_o,
  input  logic              rd_last_i,
  input  logic [WT_W-1:0]   rd_last_wt_i,
  input  logic              wr_resp_i,
  input  logic [WT_W-1:0]   wr_resp_wt_i,
  input  logic              cfg_wr_i,
  input  logic [CFG_W-1:0]  cfg_wdata_i,
  output logic [CFG_W-1:0]  cfg_rdata_o
);
  localparam int unsigned MIN_OT = RSV_SLOTS + 2;
  localparam int unsigned CNT_W  = $clog2(MAX_OT + 1);

  logic             rst_sync_n;
  logic [WT_W-1:0]  req_wt;
  logic [CNT_W-1:0] limit_w;
  logic [CNT_W-1:0] occ_w;

  ot_rst_sync #(.STAGES(2)) u_rst (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .rst_sync_no (rst_sync_n)
  );

  ot_weight #(.GRAN_W(GRAN_W), .WT_W(WT_W)) u_wt (
    .gran_i (req_gran_i),
    .dvm_i  (req_dvm_i),
    .wt_o   (req_wt)
  );

  ot_limit_reg #(
    .CFG_W(CFG_W), .CNT_W(CNT_W), .MIN_OT(MIN_OT), .MAX_OT(MAX_OT)
  ) u_lim (
    .clk_i   (clk_i),
    .rst_ni  (rst_sync_n),
    .wr_i    (cfg_wr_i),
    .wdata_i (cfg_wdata_i),
    .limit_o (limit_w)
  );

  ot_counter #(.CNT_W(CNT_W), .WT_W(WT_W)) u_cnt (
    .clk_i       (clk_i),
    .rst_ni      (rst_sync_n),
    .limit_i     (limit_w),
    .req_valid_i (req_valid_i),
    .req_wt_i    (req_wt),
    .req_ready_o (req_ready_o),
    .rd_ret_i    (rd_last_i),
    .rd_ret_wt_i (rd_last_wt_i),
    .wr_ret_i    (wr_resp_i),
    .wr_ret_wt_i (wr_resp_wt_i),
    .occ_o       (occ_w)
  );

  generate
    if (CFG_W > CNT_W) begin : g_pad
      assign cfg_rdata_o = {{(CFG_W-CNT_W){1'b0}}, limit_w};
    end else begin : g_fit
      assign cfg_rdata_o = limit_w[CFG_W-1:0];
    end
  endgenerate
endmodule

// File: rtl/ot_limiter_chk.sv
module ot_limiter_chk #(
  parameter int unsigned MAX_OT = 32,
  parameter int unsigned MIN_OT = 4,
  parameter int unsigned GRAN_W = 3,
  parameter int unsigned WT_W   = 3,
  parameter int unsigned CFG_W  = 8,
  parameter int unsigned CNT_W  = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic [GRAN_W-1:0] req_gran,
  input logic              req_dvm,
  input logic              req_ready,
  input logic              rd_v,
  input logic [WT_W-1:0]   rd_wt,
  input logic              wr_v,
  input logic [WT_W-1:0]   wr_wt,
  input logic              cfg_wr,
  input logic [CFG_W-1:0]  cfg_wdata,
  input logic [CFG_W-1:0]  cfg_rdata,
  input logic [CNT_W-1:0]  occ
);
  int cwt;
  int nxt;

  always_comb begin
    cwt = req_dvm ? 2 : ((req_gran == '0) ? 1 : int'(req_gran));
    nxt = int'(occ) + ((req_valid && req_ready) ? cwt : 0)
        - (rd_v ? int'(rd_wt) : 0) - (wr_v ? int'(wr_wt) : 0);
    if (nxt < 0) nxt = 0;
  end

  p_net_update_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rst_n |=> int'(occ) == $past(nxt));

  p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !cfg_wr) |=> int'(occ) <= int'($past(cfg_rdata)));

  p_stall_reason_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |-> (int'(occ) + cwt > int'(cfg_rdata)));

  p_limit_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(cfg_rdata) >= int'(MIN_OT)) && (int'(cfg_rdata) <= int'(MAX_OT)));

  p_limit_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_wr |=> $stable(cfg_rdata));

  p_limit_exact_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && int'(cfg_wdata) >= int'(MIN_OT) && int'(cfg_wdata) <= int'(MAX_OT))
      |=> cfg_rdata == $past(cfg_wdata));
endmodule

bind ot_limiter ot_limiter_chk #(
  .MAX_OT(MAX_OT), .MIN_OT(MIN_OT), .GRAN_W(GRAN_W),
  .WT_W(WT_W), .CFG_W(CFG_W), .CNT_W(CNT_W)
) chk_i (
  .clk       (clk_i),
  .rst_n     (rst_sync_n),
  .req_valid (req_valid_i),
  .req_gran  (req_gran_i),
  .req_dvm   (req_dvm_i),
  .req_ready (req_ready_o),
  .rd_v      (rd_last_i),
  .rd_wt     (rd_last_wt_i),
  .wr_v      (wr_resp_i),
  .wr_wt     (wr_resp_wt_i),
  .cfg_wr    (cfg_wr_i),
  .cfg_wdata (cfg_wdata_i),
  .cfg_rdata (cfg_rdata_o),
  .occ       (occ_w)
);

// File: tb/ot_limiter_tb_top.sv
module ot_limiter_tb_top;
  localparam int MAX_OT = 32;
  localparam int RSV    = 2;
  localparam int MIN_OT = RSV + 2;
  localparam int GRAN_W = 3;
  localparam int WT_W   = 3;
  localparam int CFG_W  = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic req_valid = 1'b0, req_dvm = 1'b0, req_ready;
  logic [GRAN_W-1:0] req_gran = '0;
  logic rd_last = 1'b0, wr_resp = 1'b0, cfg_wr = 1'b0;
  logic [WT_W-1:0] rd_wt = '0, wr_wt = '0;
  logic [CFG_W-1:0] cfg_wdata = '0, cfg_rdata;

  int n_chk = 0, n_bad = 0;
  int mcount = 0, mlimit = MAX_OT;

  always #2 clk = ~clk;

  ot_limiter #(.MAX_OT(MAX_OT), .RSV_SLOTS(RSV), .GRAN_W(GRAN_W), .CFG_W(CFG_W)) dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .req_valid_i(req_valid), .req_gran_i(req_gran), .req_dvm_i(req_dvm),
    .req_ready_o(req_ready),
    .rd_last_i(rd_last), .rd_last_wt_i(rd_wt),
    .wr_resp_i(wr_resp), .wr_resp_wt_i(wr_wt),
    .cfg_wr_i(cfg_wr), .cfg_wdata_i(cfg_wdata), .cfg_rdata_o(cfg_rdata)
  );

  function automatic int f_weight(bit d, int g);
    return d ? 2 : ((g == 0) ? 1 : g);
  endfunction

  function automatic int f_clamp(int v);
    if (v < MIN_OT) return MIN_OT;
    if (v > MAX_OT) return MAX_OT;
    return v;
  endfunction

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Called at a negedge; drives one cycle, checks, advances the model.
  task automatic step(bit v, int g, bit d, bit rv, int rw, bit wv, int ww,
                      bit cw, int cd, string tag);
    int ew;
    int er;
    req_valid = v; req_gran = GRAN_W'(g); req_dvm = d;
    rd_last = rv; rd_wt = WT_W'(rw);
    wr_resp = wv; wr_wt = WT_W'(ww);
    cfg_wr = cw; cfg_wdata = CFG_W'(cd);
    #1;
    ew = f_weight(d, g);
    er = (mcount + ew <= mlimit) ? 1 : 0;
    check({tag, " ready"}, int'(req_ready), er);
    check({tag, " limit"}, int'(cfg_rdata), mlimit);
    mcount = mcount + ((v && er == 1) ? ew : 0) - (rv ? rw : 0) - (wv ? ww : 0);
    if (cw) mlimit = f_clamp(cd);
    @(negedge clk);
  endtask

  initial begin
    #(4 * 200000);
    n_bad++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'h5eed_0017));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1: reset state
    step(0, 7, 0, 0, 0, 0, 0, 0, 0, "R1");
    // R3: fill to the limit with 7-granule requests
    for (int i = 0; i < 4; i++) step(1, 7, 0, 0, 0, 0, 0, 0, 0, "R3 fill");
    step(1, 5, 0, 0, 0, 0, 0, 0, 0, "R3 stall 28+5");
    // R2: zero granule weighs one, DVM weighs two regardless of granules
    step(1, 0, 0, 0, 0, 0, 0, 0, 0, "R2 zero-gran");
    step(1, 7, 1, 0, 0, 0, 0, 0, 0, "R2 dvm");
    step(1, 7, 1, 0, 0, 0, 0, 0, 0, "R2 dvm stall");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R3 exact fit");
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R3 full stall");
    // R4: retire while stalled, then accept and retire together
    step(1, 3, 0, 1, 3, 0, 0, 0, 0, "R4 rd retire");
    step(1, 3, 0, 0, 0, 1, 2, 0, 0, "R4 net update");
    step(1, 2, 0, 1, 1, 1, 1, 0, 0, "R4 both retire");
    // R5: below floor
    step(0, 1, 0, 0, 0, 0, 0, 1, 1, "R5 write 1");
    step(1, 1, 0, 0, 0, 0, 0, 1, 0, "R5 write 0");
    // R6: above ceiling and in range
    step(0, 1, 0, 0, 0, 0, 0, 1, 200, "R6 write 200");
    step(0, 1, 0, 0, 0, 0, 0, 1, 255, "R6 write 255");
    step(0, 1, 0, 0, 0, 0, 0, 1, 17, "R6 write 17");
    step(0, 1, 0, 0, 0, 0, 0, 1, 10, "R7 lower to 10");
    // R7: drain under a lowered limit
    while (mcount > 9) begin
      int w;
      w = (mcount - 9 > 7) ? 7 : mcount - 9;
      step(1, 1, 0, 1, w, 0, 0, 0, 0, "R7 drain");
    end
    step(1, 1, 0, 0, 0, 0, 0, 0, 0, "R7 fits again");
    step(0, 1, 0, 0, 0, 0, 0, 1, MAX_OT, "R6 restore");

    // Random mix
    for (int c = 0; c < 4000; c++) begin
      bit v, d, rv, wv, cw;
      int g, rw, ww, cd, avail;
      v  = ($urandom_range(0, 3) != 0);
      d  = ($urandom_range(0, 5) == 0);
      g  = $urandom_range(0, 7);
      avail = mcount;
      rv = ($urandom_range(0, 2) == 0) && (avail > 0);
      rw = rv ? $urandom_range(1, (avail > 7) ? 7 : avail) : 0;
      avail = avail - rw;
      wv = ($urandom_range(0, 2) == 0) && (avail > 0);
      ww = wv ? $urandom_range(1, (avail > 7) ? 7 : avail) : 0;
      cw = ($urandom_range(0, 60) == 0);
      cd = $urandom_range(0, 255);
      step(v, g, d, rv, rw, wv, ww, cw, cd, "R4 random");
    end

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule